// File: doc/BRIEF.md
# Serial Prefix-Code Opcode Decoder

The block turns a serial stream of variable-length opcodes into a fixed-width instruction number. It handles eight instructions. Their codes are prefix-free and are 2, 3 or 4 bits long. The shortest codes go to the instructions that occur most often, so those instructions finish decoding sooner and use less bandwidth in the stream.

One code bit enters per clock cycle, qualified by a valid strobe, and the first bit of a code comes first. The block holds the path walked so far down the code tree. When the incoming bit completes a code, it raises a one-cycle done pulse together with the instruction number and the length of the code. It then starts the next code from the root with no idle cycle needed. The code table is fixed.

Top module: `prefix_op_decoder`

## Requirements
- R1: A synchronous active-high reset clears `done` and drops any partly received code. The first valid bit after reset starts a new code.
- R2: A bit is taken only on a rising edge where `bit_valid` is high. A cycle with `bit_valid` low raises no `done` and keeps the partial code intact, so the code continues with the next valid bit.
- R3: Two-bit codes, first bit first: `11` decodes to LOAD (id 0) and `10` decodes to STORE (id 1).
- R4: Three-bit codes: `011` decodes to ADD (id 2) and `010` decodes to AND (id 3).
- R5: Four-bit codes: `0011` decodes to NOT (id 4), `0010` to SHIFT (id 5), `0001` to JUMP (id 6) and `0000` to HALT (id 7). Every four-bit path ends at a leaf.
- R6: `done` is high for exactly the one cycle that follows the rising edge that took the last bit of a code. `op_id` and `op_len` are valid while `done` is high.
- R7: `op_len` gives the length of the decoded code as an unsigned number: 2, 3 or 4.
- R8: The valid bit that follows a completed code starts a new code at the root. Codes sent back to back, with no gap, are decoded in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` on this cycle |
| bit_in | input | 1 | Next code bit, first bit of the code first |
| done | output | 1 | One-cycle pulse when a code completes |
| op_id | output | 3 | Decoded instruction number |
| op_len | output | 3 | Length in bits of the decoded code |

## Verification
The assertions rely on the stream containing only valid code bits, so a complete code never needs more than four taken bits. They also rely on `rst` being a clean synchronous level. Under these conditions the depth of the partial code is bounded, and two `done` pulses can never fall on adjacent cycles. The stimulus builds every stream by serialising whole instructions taken from the bench's own table. It inserts idle cycles only between bits. A reset in the middle of a code is applied only as a deliberate directed case. So nothing outside the code alphabet ever reaches the block.

// File: rtl/popd_pkg.sv
`timescale 1ns/1ps
package popd_pkg;
  localparam int OP_W    = 3;
  localparam int N_OPS   = 1 << OP_W;
  localparam int MAX_LEN = 4;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int DEP_W   = $clog2(MAX_LEN);
  localparam int PATH_W  = MAX_LEN - 1;

  typedef logic [OP_W-1:0]    op_t;
  typedef logic [LEN_W-1:0]   len_t;
  typedef logic [MAX_LEN-1:0] code_t;

  // Code for each instruction, right-aligned, first bit most significant.
  function automatic code_t code_of(op_t id);
    case (id)
      3'd0: code_of = code_t'(4'b0011);
      3'd1: code_of = code_t'(4'b0010);
      3'd2: code_of = code_t'(4'b0011);
      3'd3: code_of = code_t'(4'b0010);
      default: code_of = code_t'(3'd7 - id);
    endcase
  endfunction

  function automatic len_t len_of(op_t id);
    if (id < 3'd2)      len_of = len_t'(2);
    else if (id < 3'd4) len_of = len_t'(3);
    else                len_of = len_t'(4);
  endfunction
endpackage

// File: rtl/popd_path_reg.sv
`timescale 1ns/1ps
module popd_path_reg
  import popd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              leaf,
  input  logic              bit_in,
  output logic [PATH_W-1:0] path,
  output logic [DEP_W-1:0]  depth
);
  always_ff @(posedge clk) begin
    if (rst || (take && leaf)) begin
      path  <= '0;
      depth <= '0;
    end else if (take) begin
      path  <= {path[PATH_W-2:0], bit_in};
      depth <= depth + DEP_W'(1);
    end
  end
endmodule

// File: rtl/popd_leaf_match.sv
`timescale 1ns/1ps
module popd_leaf_match
  import popd_pkg::*;
(
  input  logic [PATH_W-1:0] path,
  input  logic [DEP_W-1:0]  depth,
  input  logic              bit_in,
  output logic              hit,
  output op_t               id,
  output len_t              len
);
  code_t             probe;
  len_t              probe_len;
  logic [N_OPS-1:0]  match_vec;

  assign probe     = {path, bit_in};
  assign probe_len = LEN_W'(depth) + LEN_W'(1);

  for (genvar g = 0; g < N_OPS; g++) begin : g_cmp
    assign match_vec[g] = (len_of(op_t'(g)) == probe_len) &&
                          (code_of(op_t'(g)) == probe);
  end

  always_comb begin
    id = '0;
    for (int i = 0; i < N_OPS; i++)
      if (match_vec[i]) id = op_t'(i);
  end

  assign hit = |match_vec;
  assign len = probe_len;
endmodule

// File: rtl/popd_out_reg.sv
`timescale 1ns/1ps
module popd_out_reg
  import popd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  op_t  id_in,
  input  len_t len_in,
  output logic done,
  output op_t  id_q,
  output len_t len_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      id_q  <= '0;
      len_q <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        id_q  <= id_in;
        len_q <= len_in;
      end
    end
  end
endmodule

// File: rtl/prefix_op_decoder.sv
`timescale 1ns/1ps
module prefix_op_decoder
  import popd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       done,
  output logic [2:0] op_id,
  output logic [2:0] op_len
);
  logic              accept;
  logic              leaf_hit;
  logic [PATH_W-1:0] path;
  logic [DEP_W-1:0]  depth;
  op_t               leaf_id;
  len_t              leaf_len;
  op_t               id_q;
  len_t              len_q;

  assign accept = bit_valid && !rst;

  popd_path_reg u_path (
    .clk(clk), .rst(rst), .take(accept), .leaf(leaf_hit),
    .bit_in(bit_in), .path(path), .depth(depth)
  );

  popd_leaf_match u_match (
    .path(path), .depth(depth), .bit_in(bit_in),
    .hit(leaf_hit), .id(leaf_id), .len(leaf_len)
  );

  popd_out_reg u_out (
    .clk(clk), .rst(rst), .fire(accept && leaf_hit),
    .id_in(leaf_id), .len_in(leaf_len),
    .done(done), .id_q(id_q), .len_q(len_q)
  );

  assign op_id  = 3'(id_q);
  assign op_len = 3'(len_q);
endmodule

// File: rtl/popd_checker.sv
`timescale 1ns/1ps
module popd_checker
  import popd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bit_valid,
  input logic             done,
  input logic [2:0]       op_id,
  input logic [2:0]       op_len,
  input logic             accept,
  input logic             leaf_hit,
  input logic [DEP_W-1:0] depth
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!done && depth == '0));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> (!done && $stable(depth)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_after_leaf: assert property (@(posedge clk) disable iff (rst)
    (accept && leaf_hit) |=> done);

  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !(accept && leaf_hit) |=> !done);

  a_r7_len_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (op_len >= 3'd2 && op_len <= 3'd4));

  a_r3_short_ids: assert property (@(posedge clk) disable iff (rst)
    (done && op_len == 3'd2) |-> (op_id <= 3'd1));

  a_r4_mid_ids: assert property (@(posedge clk) disable iff (rst)
    (done && op_len == 3'd3) |-> (op_id == 3'd2 || op_id == 3'd3));

  a_r5_long_ids: assert property (@(posedge clk) disable iff (rst)
    (done && op_len == 3'd4) |-> (op_id >= 3'd4));

  a_r5_full_path_is_leaf: assert property (@(posedge clk) disable iff (rst)
    (accept && depth == DEP_W'(MAX_LEN - 1)) |-> leaf_hit);

  a_r8_root_after_leaf: assert property (@(posedge clk) disable iff (rst)
    (accept && leaf_hit) |=> (depth == '0));
endmodule

bind prefix_op_decoder popd_checker u_popd_checker (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .done(done),
  .op_id(op_id), .op_len(op_len), .accept(accept),
  .leaf_hit(leaf_hit), .depth(depth)
);

// File: tb/test_prefix_op_decoder.sv
`timescale 1ns/1ps
module test_prefix_op_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       done;
  logic [2:0] op_id;
  logic [2:0] op_len;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  int  acc = 0;
  int  cnt = 0;
  bit  exp_done = 0;
  int  exp_id = 0;
  int  exp_len = 0;
  bit  was_idle = 0;
  bit  was_rst = 0;
  int  sent_q[$];

  always #2.5 clk = ~clk;

  prefix_op_decoder i_prefix_op_decoder (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .done(done), .op_id(op_id), .op_len(op_len)
  );

  function automatic int ref_lookup(int n, int v);
    ref_lookup = -1;
    if (n == 2 && v >= 2) ref_lookup = 3 - v;   // 11 LOAD, 10 STORE
    if (n == 3 && v >= 2) ref_lookup = 5 - v;   // 011 ADD, 010 AND
    if (n == 4)           ref_lookup = 7 - v;   // 0011..0000 NOT..HALT
  endfunction

  function automatic int ref_len(int id);
    return (id < 2) ? 2 : (id < 4) ? 3 : 4;
  endfunction

  function automatic int ref_code(int id);
    if (id < 2) return 3 - id;
    if (id < 4) return 5 - id;
    return 7 - id;
  endfunction

  function automatic string tag_for_len(int n);
    return (n == 2) ? "R3" : (n == 3) ? "R4" : "R5";
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  always @(posedge clk) begin
    int r;
    cyc++;
    was_idle = !bit_valid && !rst;
    was_rst  = rst;
    exp_done = 0;
    if (rst) begin
      acc = 0;
      cnt = 0;
    end else if (bit_valid) begin
      acc = acc * 2 + int'(bit_in);
      cnt++;
      r = ref_lookup(cnt, acc);
      if (r >= 0) begin
        exp_done = 1;
        exp_id   = r;
        exp_len  = cnt;
        acc = 0;
        cnt = 0;
      end
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(done == exp_done, was_rst ? "R1" : (was_idle ? "R2" : "R6"),
          int'(done), int'(exp_done));
      if (done && exp_done) begin
        chk(int'(op_id) == exp_id, tag_for_len(exp_len), int'(op_id), exp_id);
        chk(int'(op_len) == exp_len, "R7", int'(op_len), exp_len);
        if (sent_q.size() > 0) begin
          int front;
          front = sent_q.pop_front();
          chk(int'(op_id) == front, "R8", int'(op_id), front);
        end else begin
          chk(1'b0, "R8", int'(op_id), -1);
        end
      end
    end
  end

  task automatic drive(bit v, bit b);
    @(negedge clk);
    bit_valid = v;
    bit_in    = b;
  endtask

  task automatic send_op(int id, int gap_pct);
    int code;
    int n;
    code = ref_code(id);
    n    = ref_len(id);
    sent_q.push_back(id);
    for (int i = n - 1; i >= 0; i--) begin
      while (int'($urandom_range(99)) < gap_pct)
        drive(1'b0, 1'($urandom_range(1)));
      drive(1'b1, 1'((code >> i) & 1));
    end
  endtask

  initial begin
    repeat (3) drive(1'b0, 1'b0);
    rst = 1'b0;
    // directed: every instruction once, no gaps (R3, R4, R5)
    for (int id = 0; id < 8; id++) send_op(id, 0);
    // directed: every instruction with idle cycles inside the code (R2)
    for (int id = 7; id >= 0; id--) send_op(id, 60);
    // random stream with gaps
    for (int k = 0; k < 300; k++) send_op(int'($urandom_range(7)), 30);
    // back-to-back random stream (R8)
    for (int k = 0; k < 200; k++) send_op(int'($urandom_range(7)), 0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    // partial code, then reset mid-code (R1)
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1: after reset the next code must decode from the root
    send_op(0, 0);
    send_op(7, 0);
    repeat (4) drive(1'b0, 1'b0);
    chk(sent_q.size() == 0, "R8", sent_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule